// File: doc/BRIEF.md
# Platform Reset Request Register

This block is a one-byte register on the I/O bus that software uses to ask the platform for a reset. It answers at exactly one I/O port address. A write whose trigger bit is set sends a single-cycle pulse to the reset sequencer and leaves the stored value as it was. Any other write keeps only the reset-type bit and discards the rest of the byte. A read at the port returns the stored byte.

The bus side uses plain strobes and is not a stream. A write strobe or a read strobe, together with an address, is presented for one clock, and the block accepts it in that cycle. There is no back-pressure and no ready signal. Read data is combinational and is valid in the same cycle as the read strobe. The pulse output is meant for a reset sequencer, which is outside this block. That sequencer decides what to do with the stored type bit.

Top module: `sys_reset_ctl`

## Requirements
- R1: The block decodes a single 16-bit I/O address, set by a parameter whose default is 0x0CF9. Only accesses at that address affect it or are answered by it.
- R2: A write at the port with bit 2 of the data set drives `rst_req` high for exactly one cycle, in the cycle after the clock edge that samples the write.
- R3: A write at the port with bit 2 set leaves the stored byte unchanged.
- R4: A write at the port with bit 2 clear stores the data ANDed with 0x02. Bit 1 is kept and every other bit becomes 0.
- R5: When `io_rd` is high and `io_addr` matches the port, `io_rdata` carries the stored byte in the same cycle. In all other cycles `io_rdata` is 0x00.
- R6: Reset (`rst_n` low) clears the stored byte to 0x00 and holds `rst_req` low.
- R7: A write at any other address changes neither the stored byte nor `rst_req`, and a read at any other address returns 0x00.
- R8: Trigger writes on consecutive cycles each produce their own one-cycle pulse, so `rst_req` stays high for as many cycles as there were back-to-back trigger writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; 0x00 when there is no read hit |
| rst_req | output | 1 | One-cycle system reset request pulse |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high in the same cycle. They also assume that address and data are stable while a strobe is high, so that each strobe stands for exactly one access. The stimulus meets these assumptions: every write and read task raises one strobe for one clock, changes inputs only on the falling edge, and drops the strobe before the next access. Back-to-back trigger writes are the only case where a strobe stays high across edges. In that case every cycle is still a separate, complete write.

// File: rtl/sys_reset_ctl_pkg.sv
package sys_reset_ctl_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned TRIG_BIT = 2;
  localparam int unsigned TYPE_BIT = 1;
  localparam logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9;
endpackage

// File: rtl/sys_reset_addr_dec.sv
module sys_reset_addr_dec #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic match;

  assign match  = (addr == PORT_ADDR);
  assign wr_hit = wr & match;
  assign rd_hit = rd & match;
endmodule

// File: rtl/sys_reset_store.sv
module sys_reset_store #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TRIG_BIT = 2,
  parameter int unsigned TYPE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] KEEP_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << TYPE_BIT;

  logic take;
  assign take = wr_hit & ~wdata[TRIG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (take) q <= wdata & KEEP_MASK;
  end

  // R4: a plain write keeps only the type bit
  a_r4_type_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wdata[TRIG_BIT]) |=> (q == ($past(wdata) & KEEP_MASK)));

  // R3: a trigger write does not disturb the stored byte
  a_r3_trigger_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata[TRIG_BIT]) |=> $stable(q));

  // R7: no hit means no change
  a_r7_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q));

  // R4: bits other than the type bit are never set
  a_r4_no_stray_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~KEEP_MASK) == '0);
endmodule

// File: rtl/sys_reset_pulse.sv
module sys_reset_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic trig,
  output logic req
);
  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= wr_hit & trig;
  end

  // R2: a trigger write raises the request in the next cycle
  a_r2_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && trig) |=> req);

  // R7: the request is only ever caused by a trigger write at the port
  a_r7_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(wr_hit && trig));

  // R2: a single trigger write gives a pulse of one cycle only
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !(wr_hit && trig)) |=> !req);
endmodule

// File: rtl/sys_reset_ctl.sv
module sys_reset_ctl
  import sys_reset_ctl_pkg::*;
#(
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned DW       = DATA_W,
  parameter int unsigned TRIG_POS = TRIG_BIT,
  parameter int unsigned TYPE_POS = TYPE_BIT,
  parameter logic [AW-1:0] PORT   = PORT_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic          rst_req
);
  logic          wr_hit;
  logic          rd_hit;
  logic [DW-1:0] stored;

  sys_reset_addr_dec #(.ADDR_W(AW), .PORT_ADDR(PORT)) u_dec (
    .addr   (io_addr),
    .wr     (io_wr),
    .rd     (io_rd),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  sys_reset_store #(.DATA_W(DW), .TRIG_BIT(TRIG_POS), .TYPE_BIT(TYPE_POS)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .wdata  (io_wdata),
    .q      (stored)
  );

  sys_reset_pulse u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .trig   (io_wdata[TRIG_POS]),
    .req    (rst_req)
  );

  assign io_rdata = rd_hit ? stored : '0;

  // R5: a read miss always returns zero
  a_r5_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr != PORT) |-> (io_rdata == '0));

  // R6: out of reset the request is low
  a_r6_req_low_after_reset: assert property (@(posedge clk)
    !rst_n |=> !rst_req);
endmodule

// File: tb/sys_reset_ctl_tb_top.sv
module sys_reset_ctl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] PORT = 16'h0CF9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        rst_req;

  int n_run  = 0;
  int n_fail = 0;
  logic [7:0] model = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_reset_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    io_wr = 1'b0; io_rd = 1'b0; io_addr = 16'h0000; io_wdata = 8'h00;
  endtask

  // write, then check the request in the cycle after the sampling edge
  task automatic do_write(input string req, input logic [15:0] a, input logic [7:0] d);
    logic fire;
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    idle();
    fire = (a == PORT) && d[2];
    if (a == PORT && !d[2]) model = d & 8'h02;
    check(req, {7'b0, rst_req}, {7'b0, fire});
    @(negedge clk);
    check(req, {7'b0, rst_req}, 8'h00);
  endtask

  task automatic do_read(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    check(req, io_rdata, exp);
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle();
    repeat (3) @(negedge clk);
    check("R6 req in reset", {7'b0, rst_req}, 8'h00);
    rst_n = 1'b1;
    model = 8'h00;
    do_read("R6 stored clear after reset", PORT, 8'h00);
  endtask

  task automatic t_masked_store();
    do_write("R4 write ff&~4", PORT, 8'hFB);
    do_read("R4 readback type bit", PORT, 8'h02);
    do_write("R4 write 0xF9", PORT, 8'hF9);
    do_read("R4 readback cleared", PORT, 8'h00);
    do_write("R4 write 0x02", PORT, 8'h02);
    do_read("R4 readback 02", PORT, model);
  endtask

  task automatic t_trigger();
    do_write("R2 trigger 0x04", PORT, 8'h04);
    do_read("R3 stored kept after 0x04", PORT, 8'h02);
    do_write("R2 trigger 0x06", PORT, 8'h06);
    do_write("R3 clear via 0x00", PORT, 8'h00);
    do_write("R2 trigger 0xFF", PORT, 8'hFF);
    do_read("R3 stored kept after 0xFF", PORT, 8'h00);
  endtask

  task automatic t_other_addr();
    do_write("R7 set type", PORT, 8'h02);
    do_write("R7 trigger other addr", 16'h0CF8, 8'h04);
    do_write("R7 plain other addr", 16'h0CFA, 8'h00);
    do_write("R1 high bits differ", 16'h1CF9, 8'h00);
    do_read("R7 stored untouched", PORT, 8'h02);
    do_read("R5 read other addr zero", 16'h0CF8, 8'h00);
    do_read("R1 read aliased addr zero", 16'h8CF9, 8'h00);
    @(negedge clk);
    check("R5 no read strobe zero", io_rdata, 8'h00);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    io_addr = PORT; io_wdata = 8'h04; io_wr = 1'b1;
    @(negedge clk);
    check("R8 first pulse", {7'b0, rst_req}, 8'h01);
    io_wdata = 8'h0C;
    @(negedge clk);
    idle();
    check("R8 second pulse", {7'b0, rst_req}, 8'h01);
    @(negedge clk);
    check("R8 pulse ends", {7'b0, rst_req}, 8'h00);
    do_read("R8 stored kept", PORT, 8'h02);
  endtask

  initial begin
    t_reset();
    t_masked_store();
    t_trigger();
    t_other_addr();
    t_back_to_back();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_read("R6 reset clears type bit", PORT, 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule